// File: doc/BRIEF.md
# Ground-Path Guard Controller

This controller decides when the low-side switch in a load's return path may conduct. A PWM control level, which is not synchronous to the block's clock, is brought into the clock domain. Its first rising edge while the controller is idle closes the switch and drives the gate-drive enable. From that edge onward a maximum on-time budget is counted. A separate gap timer watches for the PWM activity to stop. When the PWM stays low for the whole gap window, the switch opens and the controller goes back to idle.

If the on-time budget runs out while the cycle is still live, the controller trips. The switch opens and a one-cycle fault request goes out to the pulse generator next to this block. The controller then waits until the PWM has been low for a full gap window. After that it enters a cooling lockout, and during the lockout every PWM transition is ignored. Only a fresh rising edge after the lockout starts a new cycle.

All time is measured in ticks of an enable input, nominally one per millisecond. The durations are therefore parameters given in ticks. The on-time budget is a base period scaled by a power-of-four prescaler. The cooling window is chosen from three lengths. Select codes that are reserved or invalid fall back to the longest setting.

Top module: `gpath_guard`

## Requirements
- R1: While reset is asserted and right after it, the controller is idle: state_o = 0, and sw_en, gate_en and fault_req are all 0.
- R2: In idle, a rising PWM edge moves the controller to the active state (state_o = 1). sw_en and gate_en go high in the third clock cycle after pwm_in rises, which is two synchronizer flops plus the state register.
- R3: gate_en always equals sw_en, and both are high exactly when state_o = 1.
- R4: In the active state, each high PWM level restarts the gap timer. Low gaps shorter than GAP_TICKS ticks keep the switch on. A low that lasts GAP_TICKS ticks returns the controller to idle, and the state leaves active GAP_TICKS+3 cycles after pwm_in falls (with a tick in every cycle).
- R5: If the on-time budget expires while active, the next state is the trip state (state_o = 2) with the switch off. With a tick in every cycle, the active state lasts budget+1 cycles.
- R6: fault_req is high for exactly one cycle per trip. That cycle is the first cycle of the trip state, and fault_req is never high at any other time.
- R7: The trip state ends only after pwm_in has been low for GAP_TICKS ticks. A PWM high during this wait restarts the wait, and a PWM held high keeps the controller tripped.
- R8: From the trip state the controller enters cooling (state_o = 3). While cooling, the switch stays off and PWM is ignored. Cooling always ends in idle, and a PWM level that is already high there does not restart a cycle until a new rising edge arrives.
- R9: The on-time budget is BASE_TICKS × 4^presc_sel for presc_sel codes 0 to 5. Codes 6 and 7 give BASE_TICKS × 1024.
- R10: The cooling length is COOL_SHORT for cool_sel = 0, COOL_MID for 1 and COOL_LONG for 2. Code 3 gives COOL_LONG. With a tick in every cycle, cooling lasts length+1 cycles.
- R11: Timers advance only in cycles where tick_ms is high. With the tick held low, the active state does not expire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | 1 | Raw PWM control level, asynchronous |
| tick_ms | input | 1 | Timebase enable, one cycle per tick |
| presc_sel | input | 3 | On-time prescaler select |
| cool_sel | input | 2 | Cooling window select |
| sw_en | output | 1 | Ground-path switch enable |
| gate_en | output | 1 | External gate-drive enable |
| fault_req | output | 1 | One-cycle request for the fault pulse |
| state_o | output | 2 | 0 idle, 1 active, 2 trip, 3 cooling |

## Verification
The PWM input is driven with four kinds of pattern, and each one separates different behaviour:

- **Single rise, then low.** A single rise followed by a steady low measures the gap-window exit exactly.
- **Burst of short pulses.** A burst whose gaps stay below the window shows that the gap timer restarts on every high level.
- **Held high.** A held-high level runs the controller into the on-time budget. A high kept through the trip state shows that the exit waits for a low.
- **Toggling during cooling, then held high.** Toggling while cooling, followed by a level held high into idle, shows that the lockout ignores edges and that idle needs a fresh edge.

An exhaustive sweep of all eight prescaler codes, with the cooling codes cycled alongside, confirms the budget arithmetic and the fallback for reserved codes.

// File: rtl/gpg_pkg.sv
package gpg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ON   = 2'd1,
    ST_TRIP = 2'd2,
    ST_COOL = 2'd3
  } gpg_state_e;

  // power-of-four prescaler as a shift; reserved codes take the largest
  function automatic logic [3:0] presc_shift(input logic [2:0] code);
    return (code > 3'd5) ? 4'd10 : {code, 1'b0};
  endfunction
endpackage

// File: rtl/gpg_sync.sv
module gpg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic lvl,
  output logic rise
);
  logic [STAGES-1:0] ff;
  logic              prev;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) ff[g] <= 1'b0;
        else        ff[g] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) ff[g] <= 1'b0;
        else        ff[g] <= ff[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= 1'b0;
    else        prev <= ff[STAGES-1];

  assign lvl  = ff[STAGES-1];
  assign rise = ff[STAGES-1] & ~prev;
endmodule

// File: rtl/gpg_timer.sv
module gpg_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         tick,
  input  logic [W-1:0] limit,
  output logic         done
);
  logic [W-1:0] cnt;

  assign done = (cnt == limit);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)              cnt <= '0;
    else if (clr)            cnt <= '0;
    else if (tick && !done)  cnt <= cnt + 1'b1;
endmodule

// File: rtl/gpg_limits.sv
module gpg_limits
  import gpg_pkg::*;
#(
  parameter int BASE_TICKS = 8,
  parameter int COOL_SHORT = 6,
  parameter int COOL_MID   = 30,
  parameter int COOL_LONG  = 120,
  parameter int T1W        = 14,
  parameter int CW         = 7
) (
  input  logic [2:0]     presc_sel,
  input  logic [1:0]     cool_sel,
  output logic [T1W-1:0] t1_limit,
  output logic [CW-1:0]  cool_limit
);
  assign t1_limit = T1W'(BASE_TICKS) << presc_shift(presc_sel);

  always_comb begin
    case (cool_sel)
      2'd0:    cool_limit = CW'(COOL_SHORT);
      2'd1:    cool_limit = CW'(COOL_MID);
      default: cool_limit = CW'(COOL_LONG);
    endcase
  end
endmodule

// File: rtl/gpath_guard.sv
module gpath_guard
  import gpg_pkg::*;
#(
  parameter int BASE_TICKS  = 8,
  parameter int GAP_TICKS   = 5,
  parameter int COOL_SHORT  = 6,
  parameter int COOL_MID    = 30,
  parameter int COOL_LONG   = 120,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwm_in,
  input  logic       tick_ms,
  input  logic [2:0] presc_sel,
  input  logic [1:0] cool_sel,
  output logic       sw_en,
  output logic       gate_en,
  output logic       fault_req,
  output logic [1:0] state_o
);
  localparam int T1W = $clog2(BASE_TICKS * 1024 + 1);
  localparam int GW  = $clog2(GAP_TICKS + 1);
  localparam int CW  = $clog2(COOL_LONG + 1);

  gpg_state_e     st, nx;
  logic           pwm_lvl, pwm_rise;
  logic [T1W-1:0] t1_limit;
  logic [CW-1:0]  cool_limit;
  logic           t1_done, gap_done, cool_done;
  logic           gap_clr;
  logic           sw_q, gate_q, fault_q;

  gpg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pwm_in), .lvl(pwm_lvl), .rise(pwm_rise)
  );

  gpg_limits #(
    .BASE_TICKS(BASE_TICKS), .COOL_SHORT(COOL_SHORT), .COOL_MID(COOL_MID),
    .COOL_LONG(COOL_LONG), .T1W(T1W), .CW(CW)
  ) u_limits (
    .presc_sel(presc_sel), .cool_sel(cool_sel),
    .t1_limit(t1_limit), .cool_limit(cool_limit)
  );

  // on-time budget: runs only while active
  gpg_timer #(.W(T1W)) u_ontime (
    .clk(clk), .rst_n(rst_n), .clr(st != ST_ON), .tick(tick_ms),
    .limit(t1_limit), .done(t1_done)
  );

  // gap window: restarted by any high level and by every state change
  assign gap_clr = pwm_lvl || (nx != st) || !(st == ST_ON || st == ST_TRIP);

  gpg_timer #(.W(GW)) u_gap (
    .clk(clk), .rst_n(rst_n), .clr(gap_clr), .tick(tick_ms),
    .limit(GW'(GAP_TICKS)), .done(gap_done)
  );

  gpg_timer #(.W(CW)) u_cool (
    .clk(clk), .rst_n(rst_n), .clr(st != ST_COOL), .tick(tick_ms),
    .limit(cool_limit), .done(cool_done)
  );

  always_comb begin
    nx = st;
    case (st)
      ST_IDLE: if (pwm_rise) nx = ST_ON;
      ST_ON: begin
        if (t1_done)       nx = ST_TRIP;   // budget wins over a gap end
        else if (gap_done) nx = ST_IDLE;
      end
      ST_TRIP: if (gap_done)  nx = ST_COOL;
      ST_COOL: if (cool_done) nx = ST_IDLE;
      default: nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st      <= ST_IDLE;
      sw_q    <= 1'b0;
      gate_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      st      <= nx;
      sw_q    <= (nx == ST_ON);
      gate_q  <= (nx == ST_ON);
      fault_q <= (st == ST_ON) && (nx == ST_TRIP);
    end

  assign sw_en     = sw_q;
  assign gate_en   = gate_q;
  assign fault_req = fault_q;
  assign state_o   = st;
endmodule

// File: rtl/gpath_guard_chk.sv
module gpath_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sw_en,
  input logic       gate_en,
  input logic       fault_req,
  input logic [1:0] state_o
);
  p_gate_tracks_switch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    gate_en == sw_en);

  p_switch_only_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sw_en == (state_o == 2'd1));

  p_fault_single_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fault_req |=> !fault_req);

  p_fault_on_trip_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fault_req |-> (state_o == 2'd2) && ($past(state_o) == 2'd1));

  p_trip_exits_to_cool_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd2) |=> (state_o == 2'd2 || state_o == 2'd3));

  p_cool_exits_to_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd3) |=> (state_o == 2'd3 || state_o == 2'd0));

  p_idle_only_to_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd0) |=> (state_o == 2'd0 || state_o == 2'd1));
endmodule

bind gpath_guard gpath_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sw_en(sw_en), .gate_en(gate_en),
  .fault_req(fault_req), .state_o(state_o)
);

// File: tb/gpath_guard_test.sv
module gpath_guard_test;
  localparam int BASE = 8;
  localparam int GAP  = 5;
  localparam int CS   = 6;
  localparam int CM   = 30;
  localparam int CL   = 120;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwm = 1'b0;
  logic       tick = 1'b1;
  logic [2:0] psel = 3'd0;
  logic [1:0] csel = 2'd0;
  logic       sw_en, gate_en, fault_req;
  logic [1:0] state_o;

  int checks = 0;
  int fails  = 0;
  int fr_cnt = 0;

  gpath_guard #(.BASE_TICKS(BASE), .GAP_TICKS(GAP), .COOL_SHORT(CS),
                .COOL_MID(CM), .COOL_LONG(CL)) uut (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm), .tick_ms(tick),
    .presc_sel(psel), .cool_sel(csel), .sw_en(sw_en), .gate_en(gate_en),
    .fault_req(fault_req), .state_o(state_o)
  );

  always #4 clk = ~clk;

  always @(posedge clk) if (rst_n && fault_req) fr_cnt++;

  function automatic int exp_t1(input int p);
    return (p > 5) ? BASE * 1024 : BASE * (1 << (2 * p));
  endfunction

  function automatic int exp_cool(input int c);
    return (c == 0) ? CS : (c == 1) ? CM : CL;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wait_st(input logic [1:0] s, output int n);
    n = 0;
    do begin step(); n++; end while (state_o != s && n < 40000);
  endtask

  task automatic count_st(input logic [1:0] s, output int n);
    n = 0;
    step();
    while (state_o == s && n < 40000) begin n++; step(); end
  endtask

  task automatic fault_cycle(input int p, input int c);
    int n, lat, f0;
    psel = 3'(p); csel = 2'(c);
    f0 = fr_cnt;
    pwm = 1'b1;
    wait_st(2'd1, lat);
    count_st(2'd1, n);
    chk($sformatf("R9 budget code %0d", p), n, exp_t1(p));
    chk("R5 trip after budget", state_o, 2);
    chk("R5 switch off in trip", sw_en, 0);
    chk("R6 strobe in first trip cycle", fault_req, 1);
    pwm = 1'b0;
    count_st(2'd2, n);
    chk("R7 trip exit after gap", n, GAP + 2);
    count_st(2'd3, n);
    chk($sformatf("R10 cool code %0d", c), n, exp_cool(c));
    chk("R8 cool ends in idle", state_o, 0);
    chk("R6 one strobe per trip", fr_cnt - f0, 1);
  endtask

  initial begin
    #1_600_000;
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n, lat, bad;
    repeat (4) step();
    chk("R1 reset state", state_o, 0);
    chk("R1 reset outputs", {sw_en, gate_en, fault_req}, 0);
    rst_n = 1'b1;
    step();
    chk("R1 idle after reset", state_o, 0);

    // R2 / R4: rise, short-gap burst, then a long low
    psel = 3'd2;
    pwm = 1'b1;
    wait_st(2'd1, lat);
    chk("R2 latency", lat, 3);
    chk("R2 switch on", sw_en, 1);
    chk("R3 gate on with switch", gate_en, 1);
    bad = 0;
    for (int k = 0; k < 6; k++) begin
      pwm = 1'b0;
      repeat (3) begin step(); if (state_o != 2'd1) bad++; end
      pwm = 1'b1;
      repeat (2) begin step(); if (state_o != 2'd1) bad++; end
    end
    chk("R4 short gaps keep switch on", bad, 0);
    pwm = 1'b0;
    count_st(2'd1, n);
    chk("R4 gap exit timing", n, GAP + 2);
    chk("R4 back to idle", state_o, 0);
    chk("R3 switch off in idle", {sw_en, gate_en}, 0);

    // R11: no ticks, no expiry
    repeat (3) step();
    psel = 3'd0;
    pwm = 1'b1;
    wait_st(2'd1, lat);
    tick = 1'b0;
    repeat (40) step();
    chk("R11 held active without ticks", state_o, 1);
    tick = 1'b1;
    count_st(2'd1, n);
    chk("R11 budget counted from ticks only", n, exp_t1(0));
    // R7: held high keeps trip, high during wait restarts it
    repeat (30) step();
    chk("R7 high keeps trip", state_o, 2);
    pwm = 1'b0;
    repeat (3) step();
    pwm = 1'b1;
    repeat (2) step();
    chk("R7 still tripped after interrupted wait", state_o, 2);
    pwm = 1'b0;
    csel = 2'd1;
    count_st(2'd2, n);
    chk("R7 wait restarted", n, GAP + 2);
    // R8: cooling ignores PWM
    bad = 0;
    for (int k = 0; k < 10; k++) begin
      pwm = ~pwm;
      step();
      if (state_o != 2'd3 || sw_en) bad++;
    end
    chk("R8 toggles ignored while cooling", bad, 0);
    pwm = 1'b1;
    while (state_o == 2'd3) step();
    chk("R8 cool ends in idle", state_o, 0);
    bad = 0;
    repeat (20) begin step(); if (state_o != 2'd0 || sw_en) bad++; end
    chk("R8 held level does not restart", bad, 0);
    pwm = 1'b0;
    repeat (4) step();
    pwm = 1'b1;
    wait_st(2'd1, lat);
    chk("R8 fresh edge restarts", lat, 3);
    pwm = 1'b0;
    count_st(2'd1, n);
    chk("R4 gap exit again", n, GAP + 2);

    // R9 / R10 sweep of every prescaler code, cooling codes cycled
    for (int p = 0; p < 8; p++) begin
      repeat (3) step();
      fault_cycle(p, p % 4);
    end
    repeat (3) step();
    chk("R6 no stray strobes", fault_req, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule